// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block sits beside a small 8-bit processor core and decides when the core must break off its program to serve an event. Three sources feed it with one-cycle request pulses: a USB event source and two timer/event counters. Each pulse sets that source's sticky request flag. One control register holds these flags, a global enable and a per-source enable. Firmware reads and writes the register over a single-register bus port.

When an enabled request is pending and the core reports room on its return stack, the block issues a one-cycle call request. The call carries the entry address of the winning source and an indication that the core must save only the program counter. At the same clock edge the block clears the serviced flag and the global enable, so nothing else can interrupt the handler. A return-from-interrupt pulse from the core turns the global enable back on. Any other context the handler alters must be saved by the firmware itself.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00 and no call request is issued.
- R2: Register layout: bit 0 is the global enable, bits 1/2/3 enable the USB/timer 0/timer 1 sources, and bits 4/5/6 are the USB/timer 0/timer 1 request flags (1 = enabled / pending). A bus write stores bits 0 to 6, and bit 7 always reads 0.
- R3: A request pulse sets its source's flag at the next clock edge, whatever the enable bits hold. The flag stays set until it is serviced or written to 0.
- R4: A source is taken only when the global enable, its own enable and its flag are all 1 and the stack-full input is 0. Otherwise no call request is issued.
- R5: A taken source produces `call_req` high for exactly one cycle, one edge after the taking condition holds. `call_vec` is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1.
- R6: At the edge that raises `call_req`, the serviced flag and the global enable are both cleared. The other flags and all source enables are kept.
- R7: When several sources qualify, USB wins over timer 0, and timer 0 wins over timer 1. The losers stay pending.
- R8: If a request pulse and a bus write that clears the same flag arrive in the same cycle, the flag ends up set.
- R9: A `reti` pulse sets the global enable at the next edge, unless a call is taken at that same edge.
- R10: `push_pc_only` is high in every cycle in which `call_req` is high, and low otherwise.
- R11: While `stack_full` is high, pending requests are held, not lost. The first edge after `stack_full` falls takes the highest-priority one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control register contents |
| src_req | input | 3 | Request pulses: bit 0 USB, bit 1 timer 0, bit 2 timer 1 |
| stack_full | input | 1 | Core's return stack has no free entry |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | 8 | Entry address for the call |
| push_pc_only | output | 1 | Save only the program counter on this call |

## Verification
A request pulse, or a write that completes the taking condition, shows on the register one edge later. The resulting call arrives two edges after the stimulus. Releasing `stack_full` gives a call one edge later. A `reti` pulse gives a call for a remaining pending source two edges later. The driver records the due cycle of every call it causes in a scoreboard queue. The monitor compares the vector, the push indication and the arrival cycle against that queue, and any unexpected call counts as a failure. Register reads are sampled on the falling edge, after all the edges that could change them.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Source ordering doubles as the priority order (lowest index wins)
  typedef enum logic [1:0] {
    SRC_USB  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } irq_src_e;

  localparam int unsigned MASTER_BIT = 0;
  localparam int unsigned EN_LSB     = 1;

  function automatic int unsigned flag_lsb(int unsigned n_src);
    return EN_LSB + n_src;
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_SRC-1:0]  hw_set,
  input  logic              take,
  input  logic [N_SRC-1:0]  take_oh,
  input  logic              reti,
  output logic [DATA_W-1:0] ctrl_q
);
  import irq_pkg::*;
  localparam int unsigned FLAG_LSB = flag_lsb(N_SRC);
  localparam int unsigned USED_W   = FLAG_LSB + N_SRC;

  logic [DATA_W-1:0] ctrl_d;

  // Order of precedence: write, then service clear / reti, then hardware set
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
    if (take) begin
      ctrl_d[MASTER_BIT] = 1'b0;
      for (int i = 0; i < N_SRC; i++)
        if (take_oh[i]) ctrl_d[FLAG_LSB+i] = 1'b0;
    end else if (reti) begin
      ctrl_d[MASTER_BIT] = 1'b1;
    end
    for (int i = 0; i < N_SRC; i++)
      if (hw_set[i]) ctrl_d[FLAG_LSB+i] = 1'b1;
    for (int b = USED_W; b < DATA_W; b++)
      ctrl_d[b] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag_chk
      // R8
      flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hw_set[g]) |-> ctrl_q[FLAG_LSB+g]);
    end
  endgenerate

  // R2
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[DATA_W-1] == 1'b0);

  // R9
  reti_sets_master_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reti) && !$past(take) |-> ctrl_q[MASTER_BIT]);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // Scan from the lowest priority up so the lowest index is the last to win
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
    any = |pend;
  end

  // R7
  grant_single_chk: assert final ($onehot0(grant));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned N_SRC    = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              stack_full,
  input  logic              reti,
  output logic              call_req,
  output logic [VEC_W-1:0]  call_vec,
  output logic              push_pc_only
);
  import irq_pkg::*;
  localparam int unsigned FLAG_LSB = flag_lsb(N_SRC);
  localparam int unsigned IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [N_SRC-1:0]  pend, grant;
  logic [IDX_W-1:0]  win_idx;
  logic              any_pend, take;
  logic [VEC_W-1:0]  win_vec;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_pend
      assign pend[g] = ctrl_q[MASTER_BIT] & ctrl_q[EN_LSB+g] & ctrl_q[FLAG_LSB+g];
    end
  endgenerate

  irq_prio_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_sel (
    .pend (pend),
    .grant(grant),
    .idx  (win_idx),
    .any  (any_pend)
  );

  assign take    = any_pend & ~stack_full;
  assign win_vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);

  irq_ctrl_reg #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .wr_data(bus_wdata),
    .hw_set (src_req),
    .take   (take),
    .take_oh(grant),
    .reti   (reti),
    .ctrl_q (ctrl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req     <= 1'b0;
      call_vec     <= '0;
      push_pc_only <= 1'b0;
    end else begin
      call_req     <= take;
      push_pc_only <= take;
      if (take) call_vec <= win_vec;
    end
  end

  assign bus_rdata = ctrl_q;

  // R6
  master_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !bus_rdata[MASTER_BIT]);

  // R4
  take_cond_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> $past(bus_rdata[MASTER_BIT]) && !$past(stack_full));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |=> !call_req);

  // R7
  usb_first_chk: assert property (@(posedge clk) disable iff (rst)
    call_req && $past(bus_rdata[EN_LSB] && bus_rdata[FLAG_LSB])
      |-> call_vec == VEC_W'(VEC_BASE));

  // R10
  push_match_chk: assert property (@(posedge clk) disable iff (rst)
    push_pc_only == call_req);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] src_req = '0;
  logic       stack_full = 1'b0;
  logic       reti = 1'b0;
  logic       call_req;
  logic [7:0] call_vec;
  logic       push_pc_only;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int exp_vec[$];
  int exp_due[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_req(src_req), .stack_full(stack_full),
    .reti(reti), .call_req(call_req), .call_vec(call_vec),
    .push_pc_only(push_pc_only)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_call(input int vec, input int lat);
    exp_vec.push_back(vec);
    exp_due.push_back(cyc + lat);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (call_req) begin
        if (exp_vec.size() == 0) begin
          check(0, "R4 unexpected call", int'(call_vec), 0);
        end else begin
          int v, d;
          v = exp_vec.pop_front();
          d = exp_due.pop_front();
          check(int'(call_vec) == v, "R5/R7 vector", int'(call_vec), v);
          check(cyc == d, "R5 call cycle", cyc, d);
          check(push_pc_only, "R10 push_pc_only", int'(push_pc_only), 1);
        end
      end else begin
        if (push_pc_only) check(0, "R10 push without call", 1, 0);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v; step(1); bus_wr = 1'b0;
  endtask
  task automatic pulse(input logic [2:0] m);
    src_req = m; step(1); src_req = '0;
  endtask
  task automatic do_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask
  task automatic chk_rd(input logic [7:0] e, input string req);
    check(bus_rdata == e, req, int'(bus_rdata), int'(e));
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk_rd(8'h00, "R1 reset register");
    check(!call_req, "R1 no call after reset", int'(call_req), 0);

    // R2 layout and spare bit
    wr(8'h0E); chk_rd(8'h0E, "R2 enables readback");
    wr(8'hF0); chk_rd(8'h70, "R2 bit7 reads 0");
    step(2);
    wr(8'h00); chk_rd(8'h00, "R2 clear");

    // R3 flags set regardless of enables
    pulse(3'b100); chk_rd(8'h40, "R3 timer1 flag");
    pulse(3'b001); chk_rd(8'h50, "R3 usb flag");
    wr(8'h00);

    // R4 master on, source off: no call
    wr(8'h01); pulse(3'b010); step(2);
    chk_rd(8'h21, "R4 pending but disabled");
    // enable timer0 -> call 0x08 two edges after drive
    expect_call(8'h08, 2);
    wr(8'h25); step(2);
    chk_rd(8'h04, "R6 flag and master cleared");

    // R9 reti
    do_reti(); chk_rd(8'h05, "R9 master set by reti");
    wr(8'h0F);

    // R7 priority with all three pending
    expect_call(8'h04, 2);
    pulse(3'b111); step(2);
    chk_rd(8'h6E, "R7 losers stay pending");
    expect_call(8'h08, 2);
    do_reti(); step(2);
    chk_rd(8'h4E, "R7 timer0 serviced");
    expect_call(8'h0C, 2);
    do_reti(); step(2);
    chk_rd(8'h0E, "R7 timer1 serviced");

    // R11 stack full holds request
    stack_full = 1'b1;
    do_reti(); pulse(3'b001); step(4);
    chk_rd(8'h1F, "R11 held while stack full");
    expect_call(8'h04, 1);
    stack_full = 1'b0; step(2);
    chk_rd(8'h0E, "R11 taken after release");

    // R8 hardware set beats write clear
    wr(8'h40); wr(8'h00);
    bus_wr = 1'b1; bus_wdata = 8'h00; src_req = 3'b100;
    step(1); bus_wr = 1'b0; src_req = '0;
    chk_rd(8'h40, "R8 hw set wins");
    wr(8'h00); chk_rd(8'h00, "R8 write clears later");

    step(3);
    check(exp_vec.size() == 0, "R5 missing calls", exp_vec.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule